// File: doc/BRIEF.md
# Parallel Directional Gradient Projector

The projector takes a 2x2 window of unsigned 8-bit pixels. It projects that window onto `NDIR` evenly spaced directions at once. Each direction has its own lane of four signed 9-bit coefficients and four signed multipliers. A registered adder tree sums the four products into one signed component. Every lane works on the same window in the same cycle, so a full set of `NDIR` components leaves the block every clock while windows arrive back to back. A valid strobe travels with the data through the two pipeline stages.

The coefficients are fixed-point cosines scaled by 256, so the datapath needs no fractional arithmetic. Reset loads a default set for the angles k*180/NDIR. A simple write port then replaces any single coefficient at run time, which lets the same hardware serve other kernels. The window is assembled upstream. Comparing or thresholding the components is left to the logic that follows.

Top module: `grad_projector`

## Requirements
- R1: While `rst_n` is low, and after it rises with no window accepted yet, `comp_valid` is 0 and every component reads 0.
- R2: After reset, the coefficient of direction k (0..NDIR-1) for tap j is round(256*cos(k*180/NDIR - phi_j)) in degrees, saturated to [-256, 255]. Here phi is 225, 315, 135 and 45 for taps 0, 1, 2 and 3.
- R3: Tap j is `win_pix[8j+7:8j]`, and the taps are top-left, top-right, bottom-left and bottom-right. Component k is `comp[20k+19:20k]`, a 20-bit two's complement value that is exactly the sum of coefficient(k,j) times unsigned pixel j. It is exact over the full range of pixels and coefficients.
- R4: A window accepted with `win_valid` high at clock edge t gives `comp_valid` high after edge t+2, carrying that window's components. Windows on consecutive edges give results on consecutive edges.
- R5: After an edge with no accepted window two edges earlier, `comp_valid` is 0 and every component keeps its previous value.
- R6: With `cfg_we` high at an edge, coefficient (`cfg_dir`, `cfg_tap`) takes `cfg_coef` (two's complement). A window accepted at that same edge still uses the old value. Windows accepted from the next edge on use the new one.
- R7: A write whose `cfg_dir` is NDIR or above changes no coefficient.
- R8: All NDIR directions are computed from the same window in the same cycle, each from its own coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_valid | input | 1 | Window present this cycle |
| win_pix | input | 4*PIX_W | Four unsigned pixels, tap 0 in the low byte |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_dir | input | max(1,clog2(NDIR)) | Direction index of the write |
| cfg_tap | input | 2 | Tap index of the write |
| cfg_coef | input | COEF_W | Signed coefficient value |
| comp_valid | output | 1 | Components valid |
| comp | output | NDIR*(2*COEF_W+2) | Signed components, direction 0 in the low bits |

## Verification
A coefficient write and a window can arrive at the same edge. The window must then be computed with the old coefficient, and the next window with the new one. The bench provokes this with a directed pair of full-scale windows. It also does so inside a long random stream, where writes to random directions, including an index outside the range, fall on cycles that carry windows. The bench keeps its own coefficient table and updates it only after it has computed the expected result for the window of that cycle. Any early or late update therefore shows up as a mismatched component two cycles later.

// File: rtl/grad_proj_pkg.sv
`timescale 1ns/1ps
package grad_proj_pkg;

  // Default projection weight for one tap of one direction, as an integer
  // already rounded and saturated to a COEF_W-bit two's complement range.
  function automatic int default_coef(int dir, int tap, int ndir, int coef_w);
    real pi_c, theta, phi, x;
    int  r, hi, lo;
    pi_c  = 3.141592653589793;
    theta = pi_c * dir / ndir;
    case (tap)
      0:       phi = 1.25 * pi_c;
      1:       phi = 1.75 * pi_c;
      2:       phi = 0.75 * pi_c;
      default: phi = 0.25 * pi_c;
    endcase
    x = 256.0 * $cos(theta - phi);
    if (x >= 0.0) r = $rtoi(x + 0.5);
    else          r = -$rtoi(0.5 - x);
    hi = (1 << (coef_w - 1)) - 1;
    lo = -(1 << (coef_w - 1));
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    return r;
  endfunction

endpackage

// File: rtl/coef_bank.sv
`timescale 1ns/1ps
module coef_bank #(
  parameter int NDIR   = 8,
  parameter int TAPS   = 4,
  parameter int COEF_W = 9,
  parameter int DIR_W  = 3,
  parameter int TAP_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [DIR_W-1:0]              wr_dir,
  input  logic [TAP_W-1:0]              wr_tap,
  input  logic [COEF_W-1:0]             wr_val,
  output logic [NDIR*TAPS*COEF_W-1:0]   coef_o
);

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      logic              ce;
      logic [COEF_W-1:0] q;

      always_comb ce = wr_en && (int'(wr_dir) == d) && (int'(wr_tap) == t);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= COEF_W'(grad_proj_pkg::default_coef(d, t, NDIR, COEF_W));
        else if (ce) q <= wr_val;
      end

      assign coef_o[(d*TAPS+t)*COEF_W +: COEF_W] = q;
    end
  end

  // R7: an index beyond the last direction leaves every coefficient untouched
  p_oob_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_dir) >= NDIR)) |=> $stable(coef_o));

  // R6: without a write strobe the whole bank holds
  p_bank_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(coef_o));

endmodule

// File: rtl/proj_lane.sv
`timescale 1ns/1ps
module proj_lane #(
  parameter int TAPS   = 4,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 9,
  parameter int PROD_W = 18,
  parameter int SUM_W  = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      mid_valid,
  input  logic [TAPS*PIX_W-1:0]     win,
  input  logic [TAPS*COEF_W-1:0]    coefs,
  output logic signed [SUM_W-1:0]   sum_o
);

  localparam longint MAX_MAG = longint'(TAPS) * ((longint'(1) << PIX_W) - 1)
                               * (longint'(1) << (COEF_W - 1));

  logic signed [PROD_W-1:0] prod_d [TAPS];
  logic signed [PROD_W-1:0] prod_q [TAPS];
  logic signed [SUM_W-1:0]  sum_d;
  logic signed [SUM_W-1:0]  sum_q;

  // Stage 1: one signed multiply per tap, pixel zero-extended
  for (genvar t = 0; t < TAPS; t++) begin : g_mul
    logic signed [PROD_W-1:0] pix_ext;
    logic signed [PROD_W-1:0] coef_ext;

    always_comb begin
      pix_ext   = PROD_W'(win[t*PIX_W +: PIX_W]);
      coef_ext  = PROD_W'($signed(coefs[t*COEF_W +: COEF_W]));
      prod_d[t] = pix_ext * coef_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q[t] <= '0;
      else if (in_valid) prod_q[t] <= prod_d[t];
    end
  end

  // Stage 2: widened adder over the registered products
  always_comb begin
    sum_d = '0;
    for (int t = 0; t < TAPS; t++) sum_d = sum_d + SUM_W'(prod_q[t]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else if (mid_valid) sum_q <= sum_d;
  end

  assign sum_o = sum_q;

  // R3: the component never leaves the range the taps can produce
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (longint'(sum_q) <= MAX_MAG) && (longint'(sum_q) >= -MAX_MAG));

  // R5: products hold while no window is accepted
  p_prod_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(prod_q[0]) && $stable(prod_q[TAPS-1]));

endmodule

// File: rtl/grad_projector.sv
`timescale 1ns/1ps
module grad_projector #(
  parameter int NDIR   = 8,
  parameter int PIX_W  = 8,
  parameter int COEF_W = 9,
  localparam int TAPS  = 4,
  localparam int DIR_W = (NDIR > 1) ? $clog2(NDIR) : 1,
  localparam int TAP_W = $clog2(TAPS),
  localparam int SUM_W = 2*COEF_W + TAP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    win_valid,
  input  logic [TAPS*PIX_W-1:0]   win_pix,
  input  logic                    cfg_we,
  input  logic [DIR_W-1:0]        cfg_dir,
  input  logic [TAP_W-1:0]        cfg_tap,
  input  logic [COEF_W-1:0]       cfg_coef,
  output logic                    comp_valid,
  output logic [NDIR*SUM_W-1:0]   comp
);

  localparam int PROD_W = 2*COEF_W;
  localparam int LANE_C = TAPS*COEF_W;

  logic [NDIR*LANE_C-1:0] coef_flat;
  logic                   v_mid_d, v_mid_q;
  logic                   v_out_d, v_out_q;

  coef_bank #(
    .NDIR(NDIR), .TAPS(TAPS), .COEF_W(COEF_W), .DIR_W(DIR_W), .TAP_W(TAP_W)
  ) i_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_dir (cfg_dir),
    .wr_tap (cfg_tap),
    .wr_val (cfg_coef),
    .coef_o (coef_flat)
  );

  for (genvar k = 0; k < NDIR; k++) begin : g_lane
    logic signed [SUM_W-1:0] lane_sum;

    proj_lane #(
      .TAPS(TAPS), .PIX_W(PIX_W), .COEF_W(COEF_W), .PROD_W(PROD_W), .SUM_W(SUM_W)
    ) i_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (win_valid),
      .mid_valid (v_mid_q),
      .win       (win_pix),
      .coefs     (coef_flat[k*LANE_C +: LANE_C]),
      .sum_o     (lane_sum)
    );

    assign comp[k*SUM_W +: SUM_W] = lane_sum;
  end

  // Valid pipeline matching multiplier and adder stages
  always_comb begin
    v_mid_d = win_valid;
    v_out_d = v_mid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_mid_q <= 1'b0;
      v_out_q <= 1'b0;
    end else begin
      v_mid_q <= v_mid_d;
      v_out_q <= v_out_d;
    end
  end

  assign comp_valid = v_out_q;

  // R4: an accepted window surfaces exactly two edges later
  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> ##2 comp_valid);

  // R5: no window, no result two edges later
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> ##2 !comp_valid);

  // R5: components hold whenever the output is not refreshed
  p_comp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !v_mid_q |=> $stable(comp));

endmodule

// File: tb/test_grad_projector.sv
`timescale 1ns/1ps
module test_grad_projector;

  localparam int NDIR = 3;
  localparam int SW   = 20;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             win_valid;
  logic [31:0]      win_pix;
  logic             cfg_we;
  logic [1:0]       cfg_dir;
  logic [1:0]       cfg_tap;
  logic [8:0]       cfg_coef;
  logic             comp_valid;
  logic [NDIR*SW-1:0] comp;

  grad_projector #(.NDIR(NDIR), .PIX_W(8), .COEF_W(9)) i_grad_projector (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_pix(win_pix),
    .cfg_we(cfg_we), .cfg_dir(cfg_dir), .cfg_tap(cfg_tap), .cfg_coef(cfg_coef),
    .comp_valid(comp_valid), .comp(comp)
  );

  always #2 clk = ~clk;

  int     n_chk = 0;
  int     n_fail = 0;
  bit     done = 0;
  string  cur_tag;
  int     cm [NDIR][4];
  bit     ev [3];
  longint ex [3][NDIR];
  longint last [NDIR];
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  // R2 default weights, written from the requirement in degrees
  function automatic int bdef(int k, int j);
    real deg [4];
    real x;
    int  r;
    deg[0] = 225.0; deg[1] = 315.0; deg[2] = 135.0; deg[3] = 45.0;
    x = 256.0 * $cos((180.0 * k / NDIR - deg[j]) * 3.141592653589793 / 180.0);
    r = int'($floor(x + 0.5));
    if (r > 255) r = 255;
    if (r < -256) r = -256;
    return r;
  endfunction

  function automatic longint model(int k, logic [31:0] w);
    longint s = 0;
    for (int j = 0; j < 4; j++) s += longint'(cm[k][j]) * longint'(w[8*j +: 8]);
    return s;
  endfunction

  task automatic judge(int s);
    if (ev[s%3]) begin
      check({cur_tag, " R4 valid"}, comp_valid, 1);
      for (int k = 0; k < NDIR; k++) begin
        check({cur_tag, " R8 component"}, $signed(comp[k*SW +: SW]), ex[s%3][k]);
        last[k] = ex[s%3][k];
      end
    end else begin
      check("R5 valid low", comp_valid, 0);
      for (int k = 0; k < NDIR; k++)
        check("R5 hold", $signed(comp[k*SW +: SW]), last[k]);
    end
  endtask

  // mode 0 tap sweep, 1 random with gaps and writes, 2 patterns with writes,
  // 3 unit windows, 4 same-edge write, 5 full-scale window
  task automatic stream(int len, int mode);
    logic [31:0] w;
    bit v, we;
    int rdir, rtap, rval;
    for (int i = 0; i < len + 2; i++) begin
      @(negedge clk);
      if (i >= 2) judge(i - 2);
      v = 0; w = '0; we = 0; rdir = 0; rtap = 0; rval = 0;
      if (i < len) begin
        v = 1;
        case (mode)
          0: w = 32'(i % 256) << (8 * ((i / 256) % 4));
          1: begin
            v = (rnd() % 4) != 0;
            w = rnd();
            we = (rnd() % 6) == 0;
            rdir = int'(rnd() % 4); rtap = int'(rnd() % 4);
            rval = int'(rnd() % 512) - 256;
          end
          2: begin
            case (i % 4)
              0: w = 32'hFFFF_FFFF;
              1: w = 32'h0000_0000;
              2: w = 32'h00FF_00FF;
              default: w = 32'hFF00_FF00;
            endcase
            we = (i % 3) == 0;
            rdir = i % NDIR; rtap = (i / 3) % 4;
            case ((i / 3) % 4)
              0: rval = -256;
              1: rval = 255;
              2: rval = 0;
              default: rval = -1;
            endcase
          end
          3: w = 32'd1 << (8 * (i % 4));
          4: begin
            w = 32'hFFFF_FFFF;
            we = (i == 0);
            rval = -200;
          end
          default: w = 32'hFFFF_FFFF;
        endcase
      end
      ev[i%3] = v;
      if (v) for (int k = 0; k < NDIR; k++) ex[i%3][k] = model(k, w);
      win_valid = v; win_pix = w;
      cfg_we = we; cfg_dir = rdir[1:0]; cfg_tap = rtap[1:0]; cfg_coef = rval[8:0];
      if (we && rdir < NDIR) cm[rdir][rtap] = rval;
    end
    @(negedge clk);
    win_valid = 0; cfg_we = 0;
  endtask

  task automatic write_coef(int d, int t, int val);
    @(negedge clk);
    cfg_we = 1; cfg_dir = d[1:0]; cfg_tap = t[1:0]; cfg_coef = val[8:0];
    if (d < NDIR) cm[d][t] = val;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; win_valid = 0; win_pix = '0;
    cfg_we = 0; cfg_dir = '0; cfg_tap = '0; cfg_coef = '0;
    for (int k = 0; k < NDIR; k++) begin
      last[k] = 0;
      for (int j = 0; j < 4; j++) cm[k][j] = bdef(k, j);
    end
    repeat (3) @(negedge clk);
    check("R1 valid in reset", comp_valid, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 valid after reset", comp_valid, 0);
    for (int k = 0; k < NDIR; k++) check("R1 component", $signed(comp[k*SW +: SW]), 0);

    cur_tag = "R2"; stream(8, 3);
    cur_tag = "R3"; stream(1024, 0);
    write_coef(3, 0, 77);                // R7: out of range, no effect
    cur_tag = "R7"; stream(8, 3);
    cur_tag = "R6"; stream(2, 4);
    for (int j = 0; j < 4; j++) begin   // R3 full-scale extremes
      write_coef(0, j, -256);
      write_coef(1, j, 255);
      write_coef(2, j, (j % 2) ? 255 : -256);
    end
    cur_tag = "R3 extreme"; stream(4, 5);
    cur_tag = "R6 pattern"; stream(200, 2);
    cur_tag = "R4 random"; stream(3000, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule